// File: doc/BRIEF.md
# Routed Level Interrupt Aggregator

This block gathers nine level-sensitive interrupt inputs and presents them on three request lines to an upstream interrupt controller. Every raw input passes through a two-flop synchronizer. A per-source polarity setting then turns it into an "active" indication. Three sources have a fixed sense that software cannot change.

Each request line owns a single 32-bit register. The register holds one enable bit and one pending flag per source. Any source can therefore be steered to any combination of lines. A pending flag latches while its source is active, whether or not it is enabled. Software clears a flag by writing 1 to it. A line is raised while any of its sources is both enabled and pending. Software reaches all state through a flat read/write port with a combinational read path.

Top module: `lvl_irq_steer`

## Requirements
- R1: While reset (active low, synchronous) is applied, every register reads 0 and all request lines are low.
- R2: The polarity register sits at byte address 0x00 and holds bits 8:0. A 1 in bit n makes source n active high and a 0 makes it active low. Bits 31:9 read 0 and ignore writes.
- R3: The line registers sit at byte addresses 0x04, 0x08 and 0x0C for lines 0, 1 and 2. Bits 8:0 are the per-source enables and bits 24:16 are the per-source pending flags (bit 16+n belongs to source n). All other bits read 0 and ignore writes, and any other address reads 0.
- R4: When a raw input changes before rising edge k, the matching pending flag sets after edge k+2 if the source is then active. The flag sets on every line whether or not it is enabled there.
- R5: A pending flag stays set after its source goes inactive, until software acknowledges it.
- R6: Writing 1 to pending bit 16+n of a line register clears that flag on that edge, and writing 0 leaves it unchanged. If the source is still active, the flag sets again one edge later.
- R7: Sources 1 and 8 are always active high and source 2 is always active low, whatever their polarity bits say. The stored polarity bits still read back as written.
- R8: Request line n is high exactly when some source has both its enable bit and its pending flag set in line n's register.
- R9: The three line registers are independent. Writing one line's register changes neither the enables nor the pending flags of the others.
- R10: Writing 0x01FF0000 to a line register clears all of its enables and all of its pending flags in one write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, captured on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_src | input | 9 | Raw asynchronous interrupt inputs |
| irq_req | output | 3 | Level request lines to the upstream controller |

## Verification
The bench goes after five corner cases.

- Acknowledge while the source is still active. A design that merged set and clear in the wrong order would either never show the one-cycle drop or would lose the flag for good.
- A 0 written into a pending bit. A design that treated the pending field as plain storage would wipe flags it should keep.
- The three fixed-sense sources, driven with a polarity word that contradicts them. A design that forgot the override would latch an idle input or miss a real one.
- Latency through the synchronizer, checked on the exact edge. An extra or missing stage moves the flag by a cycle.
- Per-line isolation, checked while the same source pends on several lines at once. A decoder that aliased addresses would disturb a neighbouring line.

// File: rtl/lvl_irq_pkg.sv
// Shared constants and helpers for the routed level interrupt aggregator.
// Assumes byte addressing with 32-bit registers on a 4-byte stride.
package lvl_irq_pkg;
    localparam int REG_W       = 32;
    localparam int CFG_OFFSET  = 0;
    localparam int LINE_BASE   = 4;
    localparam int LINE_STRIDE = 4;

    // Byte offset of the register that belongs to request line j.
    function automatic int line_offset(input int j);
        return LINE_BASE + LINE_STRIDE * j;
    endfunction
endpackage

// File: rtl/lvl_irq_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is a slow level, so bits need no mutual coherence.
module lvl_irq_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lvl_irq_polarity.sv
// Holds the software polarity word and turns synchronized levels into
// per-source "active" flags. Sources in FIXED_MASK ignore the stored bit
// and use FIXED_LEVEL instead. Assumes sync_in is already synchronized.
module lvl_irq_polarity #(
    parameter int                  NUM_SRC     = 9,
    parameter logic [NUM_SRC-1:0]  FIXED_MASK  = 9'b1_0000_0110,
    parameter logic [NUM_SRC-1:0]  FIXED_LEVEL = 9'b1_0000_0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pol_we,
    input  logic [NUM_SRC-1:0] pol_wdata,
    output logic [NUM_SRC-1:0] pol_q,
    input  logic [NUM_SRC-1:0] sync_in,
    output logic [NUM_SRC-1:0] active
);
    logic [NUM_SRC-1:0] eff_pol;

    // Store the software polarity word.
    always_ff @(posedge clk) begin
        if (!rst_n)      pol_q <= '0;
        else if (pol_we) pol_q <= pol_wdata;
    end

    // Merge the stored polarity with the fixed sense, then compare with the level.
    always_comb begin
        eff_pol = (pol_q & ~FIXED_MASK) | (FIXED_LEVEL & FIXED_MASK);
        active  = ~(sync_in ^ eff_pol);
    end

    AST_FIXED_IGNORES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync_in & FIXED_MASK) == ($past(sync_in) & FIXED_MASK))
        |-> ((active & FIXED_MASK) == ($past(active) & FIXED_MASK))); // R7

    AST_POL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        pol_we |=> (pol_q == $past(pol_wdata))); // R2
endmodule

// File: rtl/lvl_irq_line.sv
// One request line: per-source enables and sticky pending flags.
// An acknowledge (write 1) wins over a set on the same edge, so a source
// that is still active re-pends one edge later. Assumes 'active' is synchronous.
module lvl_irq_line #(
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [NUM_SRC-1:0] wr_en_bits,
    input  logic [NUM_SRC-1:0] wr_ack_bits,
    input  logic [NUM_SRC-1:0] active,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] pend_q,
    output logic               req
);
    logic [NUM_SRC-1:0] clr;

    // Acknowledge mask, non-zero only on a write that targets this line.
    assign clr = wr_hit ? wr_ack_bits : '0;

    // Update the enables and the sticky pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            if (wr_hit) en_q <= wr_en_bits;
            pend_q <= (pend_q | active) & ~clr;
        end
    end

    // Raise the line while any enabled source is pending.
    assign req = |(en_q & pend_q);

    AST_PEND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(active) & ~$past(clr)) & ~pend_q) == '0)); // R4

    AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend_q & ~$past(pend_q)) & ~$past(active)) == '0)); // R4

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(clr)) & ~pend_q) == '0)); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(clr) & pend_q) == '0)); // R6

    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (wr_en_bits == '0) && (&wr_ack_bits))
        |=> ((pend_q == '0) && (en_q == '0))); // R10
endmodule

// File: rtl/lvl_irq_steer.sv
// Top of the routed level interrupt aggregator: synchronizer, polarity
// stage, one line register per request line, address decode and read mux.
// Assumes single-cycle register writes and a combinational read path.
module lvl_irq_steer
    import lvl_irq_pkg::*;
#(
    parameter int                 NUM_SRC     = 9,
    parameter int                 NUM_LINES   = 3,
    parameter int                 ADDR_W      = 8,
    parameter int                 SYNC_STAGES = 2,
    parameter int                 PEND_LSB    = 16,
    parameter logic [NUM_SRC-1:0] FIXED_MASK  = 9'b1_0000_0110,
    parameter logic [NUM_SRC-1:0] FIXED_LEVEL = 9'b1_0000_0010
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NUM_SRC-1:0]   irq_src,
    output logic [NUM_LINES-1:0] irq_req
);
    localparam logic [REG_W-1:0] SRC_ONES  = REG_W'((64'd1 << NUM_SRC) - 64'd1);
    localparam logic [REG_W-1:0] USED_MASK = SRC_ONES | (SRC_ONES << PEND_LSB);

    logic [NUM_SRC-1:0]   sync_lvl;
    logic [NUM_SRC-1:0]   src_active;
    logic [NUM_SRC-1:0]   pol_q;
    logic                 cfg_hit;
    logic [NUM_LINES-1:0] line_hit;
    logic [NUM_SRC-1:0]   en_q   [NUM_LINES];
    logic [NUM_SRC-1:0]   pend_q [NUM_LINES];
    logic                 unused_wdata;

    // Write data bits outside the enable and pending fields have no storage.
    assign unused_wdata = ^(reg_wdata & ~USED_MASK);

    // Decode the polarity register address.
    assign cfg_hit = (reg_addr == ADDR_W'(CFG_OFFSET));

    lvl_irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_src),
        .q     (sync_lvl)
    );

    lvl_irq_polarity #(
        .NUM_SRC     (NUM_SRC),
        .FIXED_MASK  (FIXED_MASK),
        .FIXED_LEVEL (FIXED_LEVEL)
    ) u_pol (
        .clk       (clk),
        .rst_n     (rst_n),
        .pol_we    (reg_we && cfg_hit),
        .pol_wdata (reg_wdata[NUM_SRC-1:0]),
        .pol_q     (pol_q),
        .sync_in   (sync_lvl),
        .active    (src_active)
    );

    for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
        localparam int OFF = line_offset(j);

        // Decode this line's register address.
        assign line_hit[j] = (reg_addr == ADDR_W'(OFF));

        lvl_irq_line #(.NUM_SRC(NUM_SRC)) u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_hit      (reg_we && line_hit[j]),
            .wr_en_bits  (reg_wdata[NUM_SRC-1:0]),
            .wr_ack_bits (reg_wdata[PEND_LSB +: NUM_SRC]),
            .active      (src_active),
            .en_q        (en_q[j]),
            .pend_q      (pend_q[j]),
            .req         (irq_req[j])
        );
    end

    // Select the addressed register onto the read bus.
    always_comb begin
        reg_rdata = '0;
        if (cfg_hit) reg_rdata[NUM_SRC-1:0] = pol_q;
        for (int j = 0; j < NUM_LINES; j++) begin
            if (line_hit[j]) begin
                reg_rdata[NUM_SRC-1:0]          = en_q[j];
                reg_rdata[PEND_LSB +: NUM_SRC]  = pend_q[j];
            end
        end
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rdata & ~USED_MASK) == '0)); // R3

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> ((reg_rdata == '0) && (irq_req == '0))); // R1
endmodule

// File: tb/sim_lvl_irq_steer.sv
module sim_lvl_irq_steer;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  reg_addr = 0;
    logic        reg_we = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [8:0]  irq_src;
    logic [2:0]  irq_req;

    localparam logic [8:0] IDLE = 9'b0_1111_1101;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #4 clk = ~clk;

    lvl_irq_steer u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_src(irq_src), .irq_req(irq_req)
    );

    // ---------------- behavioural reference model ----------------
    logic [8:0] m_s1, m_s2, m_pol;
    logic [8:0] m_en [3];
    logic [8:0] m_pd [3];

    function automatic bit is_active(int s, logic lvl, logic pol);
        if (s == 1 || s == 8) return lvl;
        if (s == 2)           return !lvl;
        return pol ? lvl : !lvl;
    endfunction

    always @(posedge clk) begin
        logic [8:0] n_en [3];
        logic [8:0] n_pd [3];
        logic [8:0] n_pol;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_pol = 0;
            for (int l = 0; l < 3; l++) begin m_en[l] = 0; m_pd[l] = 0; end
        end else begin
            n_pol = m_pol;
            if (reg_we && reg_addr == 8'h00) n_pol = reg_wdata[8:0];
            for (int l = 0; l < 3; l++) begin
                bit hit;
                hit = reg_we && (reg_addr == 8'(4 * (l + 1)));
                n_en[l] = hit ? reg_wdata[8:0] : m_en[l];
                for (int s = 0; s < 9; s++) begin
                    if (hit && reg_wdata[16 + s]) n_pd[l][s] = 1'b0;
                    else n_pd[l][s] = m_pd[l][s] | is_active(s, m_s2[s], m_pol[s]);
                end
            end
            m_s2 = m_s1;
            m_s1 = irq_src;
            m_pol = n_pol;
            for (int l = 0; l < 3; l++) begin m_en[l] = n_en[l]; m_pd[l] = n_pd[l]; end
        end
    end

    function automatic logic [31:0] model_rd(logic [7:0] a);
        if (a == 8'h00) return {23'd0, m_pol};
        for (int l = 0; l < 3; l++)
            if (a == 8'(4 * (l + 1))) return {7'd0, m_pd[l], 7'd0, m_en[l]};
        return 32'd0;
    endfunction

    function automatic logic [2:0] model_irq();
        logic [2:0] r;
        for (int l = 0; l < 3; l++) r[l] = |(m_en[l] & m_pd[l]);
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Compare against the model on every cycle, away from the clock edge.
    always @(negedge clk) begin
        if (!done) begin
            chk({cur_req, " rdata(model)"}, reg_rdata, model_rd(reg_addr));
            chk({cur_req, " irq(model)"}, {29'd0, irq_req}, {29'd0, model_irq()});
        end
    end

    // ---------------- stimulus helpers (enter/leave at posedge+2) ----------------
    task automatic step(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1;
        @(posedge clk); #2;
        reg_we = 0;
    endtask

    task automatic rdi(string req, logic [7:0] a, logic [31:0] exp_rd, logic [2:0] exp_irq);
        reg_addr = a;
        @(negedge clk);
        chk({req, " rdata"}, reg_rdata, exp_rd);
        chk({req, " irq"}, {29'd0, irq_req}, {29'd0, exp_irq});
        @(posedge clk); #2;
    endtask

    task automatic flush_all();
        wr(8'h04, 32'h01FF0000);
        wr(8'h08, 32'h01FF0000);
        wr(8'h0C, 32'h01FF0000);
    endtask

    task automatic report();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        irq_src = IDLE;
        step(1);
        // R1: registers and lines are zero while reset is held
        cur_req = "R1";
        rdi("R1", 8'h00, 0, 0);
        rdi("R1", 8'h04, 0, 0);
        rdi("R1", 8'h08, 0, 0);
        rdi("R1", 8'h0C, 0, 0);
        rst_n = 1;
        step(6);
        flush_all();
        step(1);

        // R3: layout, reserved bits, unmapped address
        cur_req = "R3";
        rdi("R3", 8'h04, 0, 0);
        wr(8'h04, 32'hFFFFFFFF);
        rdi("R3", 8'h04, 32'h000001FF, 0);
        wr(8'h10, 32'hFFFFFFFF);
        rdi("R3", 8'h10, 0, 0);
        cur_req = "R10";
        wr(8'h04, 32'h01FF0000);
        rdi("R10", 8'h04, 0, 0);

        // R4 / R8 / R9: sync latency, line steering, independence
        cur_req = "R4";
        wr(8'h08, 32'h00000001);
        irq_src[0] = 1'b0;
        step(2);
        rdi("R4", 8'h08, 32'h00000001, 3'b000);
        rdi("R4", 8'h08, 32'h00010001, 3'b010);
        rdi("R8", 8'h0C, 32'h00010000, 3'b010);
        rdi("R9", 8'h04, 32'h00010000, 3'b010);

        // R5: sticky after the source goes inactive
        cur_req = "R5";
        irq_src[0] = 1'b1;
        step(5);
        rdi("R5", 8'h08, 32'h00010001, 3'b010);

        // R6: write-one-to-clear, zero keeps, re-pend while active
        cur_req = "R6";
        wr(8'h08, 32'h00000001);
        rdi("R6", 8'h08, 32'h00010001, 3'b010);
        wr(8'h08, 32'h00010001);
        rdi("R6", 8'h08, 32'h00000001, 3'b000);
        rdi("R9", 8'h04, 32'h00010000, 3'b000);
        irq_src[0] = 1'b0;
        step(3);
        rdi("R6", 8'h08, 32'h00010001, 3'b010);
        wr(8'h08, 32'h00010001);
        rdi("R6", 8'h08, 32'h00000001, 3'b000);
        rdi("R6", 8'h08, 32'h00010001, 3'b010);
        irq_src[0] = 1'b1;
        step(3);
        flush_all();
        step(1);

        // R2: polarity register readback and effect
        cur_req = "R2";
        wr(8'h00, 32'hFFFF0001);
        rdi("R2", 8'h00, 32'h00000001, 0);
        rdi("R2", 8'h04, 32'h00010000, 0);
        wr(8'h00, 32'h0);
        step(2);
        flush_all();
        step(1);

        // R7: fixed-sense sources ignore the polarity word
        cur_req = "R7";
        wr(8'h00, 32'h00000004);
        rdi("R7", 8'h00, 32'h00000004, 0);
        irq_src[1] = 1'b1;
        step(2);
        rdi("R7", 8'h0C, 32'h00000000, 0);
        rdi("R7", 8'h0C, 32'h00020000, 0);
        irq_src[8] = 1'b1;
        step(3);
        rdi("R7", 8'h0C, 32'h01020000, 0);
        irq_src[1] = 1'b0; irq_src[8] = 1'b0; irq_src[2] = 1'b0;
        step(3);
        wr(8'h0C, 32'h01FF0000);
        rdi("R7", 8'h0C, 32'h00000000, 0);
        rdi("R7", 8'h0C, 32'h00040000, 0);
        irq_src = IDLE;
        step(3);
        wr(8'h00, 32'h0);
        step(2);
        flush_all();
        step(1);

        // R10: one write disables and clears a busy line
        cur_req = "R10";
        wr(8'h04, 32'h000001FF);
        irq_src[0] = 1'b0;
        step(4);
        rdi("R10", 8'h04, 32'h000101FF, 3'b001);
        irq_src[0] = 1'b1;
        step(3);
        wr(8'h04, 32'h01FF0000);
        rdi("R10", 8'h04, 0, 0);
        flush_all();

        // R8: random traffic compared against the model every cycle
        cur_req = "R8";
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 5) irq_src[$urandom % 9] ^= 1'b1;
            if (r == 7 || r == 9) begin
                reg_addr  = 8'(4 * ($urandom % 5));
                reg_wdata = $urandom;
                reg_we    = 1;
            end else begin
                reg_we   = 0;
                reg_addr = 8'(4 * ($urandom % 5));
            end
            step(1);
        end
        reg_we = 0;
        step(2);
        report();
    end
endmodule